// File: doc/BRIEF.md
# Word Load/Store Unit with Stack Push and Pop

This unit turns one decoded memory instruction into a word access on a byte-addressed memory with 32-bit words. It accepts the opcode, the three register indices, the three register values and a 16-bit immediate. In the same cycle it forms the effective address and, when the address is word aligned, raises a memory request. One cycle later it finishes the instruction. It pulses a completion flag and drives up to two register writebacks. One writeback returns loaded data and the other returns an updated base register.

Four addressing forms are supported. Base plus sign-extended displacement and base plus index serve both loads and stores. Pop reads at the base address and then advances the base by the signed displacement. Push first moves the base by the displacement and then stores at the moved address. A new instruction may be presented on every cycle. The memory is external and returns read data one cycle after the request.

Top module: `lsu_top`

## Requirements
- R1: Opcode 32 loads register a from address Rb + sext(imm). Opcode 33 loads register a from address Rb + Rc. The loaded word appears on the first writeback port in the cycle after the request.
- R2: Opcode 36 writes Ra to address Rb + sext(imm), and opcode 37 writes Ra to address Rb + Rc. Each raises the request with write enable set and Ra on the write data.
- R3: Opcode 34 (pop) reads at address Rb and loads the word into register a. In the next cycle it also writes Rb + sext(imm) to register b on the second writeback port.
- R4: Opcode 38 (push) stores Ra at address Rb + sext(imm). In the next cycle it writes that same sum to register b on the second writeback port.
- R5: When a pop names the same register for a and b, only the base update is written, so the updated base is the value that remains.
- R6: An operand whose register index is 0 is used as zero, whatever value is driven for it.
- R7: No writeback is ever issued to register index 0.
- R8: When the low two bits of the effective address are nonzero, no memory request is raised. In the next cycle completion and the misalignment error pulse together, with no writeback.
- R9: An instruction presented with the valid input raises its request in the same cycle and completes exactly one cycle later. Instructions may be presented back to back.
- R10: A valid instruction whose opcode is not one of 32, 33, 34, 36, 37 or 38 raises no request, no completion and no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Instruction present this cycle |
| req_op | input | 6 | Opcode |
| req_a_idx | input | 5 | Data register index (load target, store source) |
| req_b_idx | input | 5 | Base register index |
| req_c_idx | input | 5 | Index register index |
| req_a_val | input | 32 | Value of the data register |
| req_b_val | input | 32 | Value of the base register |
| req_c_val | input | 32 | Value of the index register |
| req_imm | input | 16 | Signed displacement |
| mem_req | output | 1 | Memory access this cycle |
| mem_addr | output | 32 | Byte address of the access |
| mem_we | output | 1 | Access is a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| done | output | 1 | Instruction completed |
| misalign_err | output | 1 | Completed instruction had a misaligned address |
| wb_ld_en | output | 1 | Load-data writeback enable |
| wb_ld_idx | output | 5 | Load-data writeback register |
| wb_ld_data | output | 32 | Load-data writeback value |
| wb_base_en | output | 1 | Base-update writeback enable |
| wb_base_idx | output | 5 | Base-update writeback register |
| wb_base_data | output | 32 | Base-update writeback value |

## Verification
The bench pushes two words onto a stack and pops them back. A design that applies the base update at the wrong moment, before or after the access, returns the words from the wrong slots. It also leaves the stack pointer off. A pop whose target and base are the same register is aimed at the write-ordering rule: a design that lets the load win leaves memory data where the moved pointer belongs. Register zero is driven with a nonzero value, both as a base and as a store source, so a design that trusts the value lines produces wrong addresses or stores that value. Misaligned loads, stores and pushes are also issued. A design that still raises the request corrupts memory, and a design that still updates the base leaves the stack pointer moved, and later pops then read wrong words.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    parameter int DATA_W = 32;
    parameter int IDX_W  = 5;
    parameter int OP_W   = 6;
    parameter int IMM_W  = 16;
    localparam int ALIGN_BITS = $clog2(DATA_W / 8);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  ridx_t;

    typedef enum logic [OP_W-1:0] {
        OPC_LOAD_DISP  = 6'd32,
        OPC_LOAD_INDEX = 6'd33,
        OPC_POP_POST   = 6'd34,
        OPC_STORE_DISP = 6'd36,
        OPC_STORE_INDX = 6'd37,
        OPC_PUSH_PRE   = 6'd38
    } mem_opc_e;

    typedef struct packed {
        logic is_load;
        logic is_store;
        logic use_index;
        logic moves_base;
        logic addr_is_new_base;
    } opc_class_t;

    typedef struct packed {
        logic  valid;
        logic  err;
        logic  load_wr;
        ridx_t load_idx;
        logic  base_wr;
        ridx_t base_idx;
        word_t base_val;
    } stage_t;

    function automatic opc_class_t classify(input logic [OP_W-1:0] op);
        opc_class_t k;
        k = '0;
        case (op)
            OPC_LOAD_DISP:  k.is_load = 1'b1;
            OPC_LOAD_INDEX: begin k.is_load = 1'b1; k.use_index = 1'b1; end
            OPC_POP_POST:   begin k.is_load = 1'b1; k.moves_base = 1'b1; end
            OPC_STORE_DISP: k.is_store = 1'b1;
            OPC_STORE_INDX: begin k.is_store = 1'b1; k.use_index = 1'b1; end
            OPC_PUSH_PRE:   begin
                k.is_store = 1'b1;
                k.moves_base = 1'b1;
                k.addr_is_new_base = 1'b1;
            end
            default: k = '0;
        endcase
        return k;
    endfunction

    function automatic word_t widen_imm(input logic [IMM_W-1:0] imm);
        return word_t'($signed(imm));
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
(
    input  logic              req_valid,
    input  logic [OP_W-1:0]   req_op,
    input  ridx_t             idx_a,
    input  ridx_t             idx_b,
    input  ridx_t             idx_c,
    input  word_t             val_a,
    input  word_t             val_b,
    input  word_t             val_c,
    input  logic [IMM_W-1:0]  imm,
    output logic              mem_req,
    output word_t             mem_addr,
    output logic              mem_we,
    output word_t             mem_wdata,
    output stage_t            issue
);

    localparam int N_OPND = 3;

    ridx_t      sel_idx [N_OPND];
    word_t      sel_raw [N_OPND];
    word_t      opnd    [N_OPND];
    opc_class_t cls;
    word_t      disp;
    word_t      moved;
    word_t      eff;
    logic       active;
    logic       misal;

    assign sel_idx[0] = idx_a;
    assign sel_idx[1] = idx_b;
    assign sel_idx[2] = idx_c;
    assign sel_raw[0] = val_a;
    assign sel_raw[1] = val_b;
    assign sel_raw[2] = val_c;

    // register zero is hard-wired to zero on every operand lane
    generate
        for (genvar g = 0; g < N_OPND; g++) begin : g_zero
            assign opnd[g] = (sel_idx[g] == '0) ? '0 : sel_raw[g];
        end
    endgenerate

    always_comb begin
        cls    = classify(req_op);
        disp   = cls.use_index ? opnd[2] : widen_imm(imm);
        moved  = opnd[1] + disp;
        eff    = (cls.moves_base && !cls.addr_is_new_base) ? opnd[1] : moved;
        misal  = |eff[ALIGN_BITS-1:0];
        active = req_valid && (cls.is_load || cls.is_store);

        mem_req   = active && !misal;
        mem_we    = mem_req && cls.is_store;
        mem_addr  = eff;
        mem_wdata = opnd[0];

        issue.valid    = active;
        issue.err      = misal;
        issue.load_wr  = cls.is_load && (idx_a != '0);
        issue.load_idx = idx_a;
        issue.base_wr  = cls.moves_base && (idx_b != '0);
        issue.base_idx = idx_b;
        issue.base_val = moved;
    end

endmodule

// File: rtl/lsu_wb.sv
module lsu_wb
    import lsu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  stage_t issue,
    input  word_t  rdata,
    output logic   done,
    output logic   err,
    output logic   ld_en,
    output ridx_t  ld_idx,
    output word_t  ld_data,
    output logic   base_en,
    output ridx_t  base_idx,
    output word_t  base_data
);

    stage_t q;
    logic   ok;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= issue;
    end

    always_comb begin
        ok        = q.valid && !q.err;
        done      = q.valid;
        err       = q.valid && q.err;
        base_en   = ok && q.base_wr;
        base_idx  = q.base_idx;
        base_data = q.base_val;
        // base update is the later write: it wins on a shared target
        ld_en     = ok && q.load_wr && !(base_en && (q.load_idx == q.base_idx));
        ld_idx    = q.load_idx;
        ld_data   = rdata;
    end

endmodule

// File: rtl/lsu_top.sv
module lsu_top
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [OP_W-1:0]   req_op,
    input  logic [IDX_W-1:0]  req_a_idx,
    input  logic [IDX_W-1:0]  req_b_idx,
    input  logic [IDX_W-1:0]  req_c_idx,
    input  logic [DATA_W-1:0] req_a_val,
    input  logic [DATA_W-1:0] req_b_val,
    input  logic [DATA_W-1:0] req_c_val,
    input  logic [IMM_W-1:0]  req_imm,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              misalign_err,
    output logic              wb_ld_en,
    output logic [IDX_W-1:0]  wb_ld_idx,
    output logic [DATA_W-1:0] wb_ld_data,
    output logic              wb_base_en,
    output logic [IDX_W-1:0]  wb_base_idx,
    output logic [DATA_W-1:0] wb_base_data
);

    stage_t issue;

    lsu_agen u_agen (
        .req_valid (req_valid),
        .req_op    (req_op),
        .idx_a     (req_a_idx),
        .idx_b     (req_b_idx),
        .idx_c     (req_c_idx),
        .val_a     (req_a_val),
        .val_b     (req_b_val),
        .val_c     (req_c_val),
        .imm       (req_imm),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .issue     (issue)
    );

    lsu_wb u_wb (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .rdata     (mem_rdata),
        .done      (done),
        .err       (misalign_err),
        .ld_en     (wb_ld_en),
        .ld_idx    (wb_ld_idx),
        .ld_data   (wb_ld_data),
        .base_en   (wb_base_en),
        .base_idx  (wb_base_idx),
        .base_data (wb_base_data)
    );

endmodule

// File: rtl/lsu_chk.sv
module lsu_chk
    import lsu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              mem_req,
    input logic [DATA_W-1:0] mem_addr,
    input logic              done,
    input logic              misalign_err,
    input logic              wb_ld_en,
    input logic [IDX_W-1:0]  wb_ld_idx,
    input logic              wb_base_en,
    input logic [IDX_W-1:0]  wb_base_idx
);

    assert_req_completes_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> (done && !misalign_err));

    assert_req_aligned_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[ALIGN_BITS-1:0] == '0));

    assert_err_no_wb_R8: assert property (@(posedge clk) disable iff (rst)
        misalign_err |-> (done && !wb_ld_en && !wb_base_en));

    assert_ld_not_r0_R7: assert property (@(posedge clk) disable iff (rst)
        wb_ld_en |-> (wb_ld_idx != '0));

    assert_base_not_r0_R7: assert property (@(posedge clk) disable iff (rst)
        wb_base_en |-> (wb_base_idx != '0));

    assert_single_writer_R5: assert property (@(posedge clk) disable iff (rst)
        (wb_ld_en && wb_base_en) |-> (wb_ld_idx != wb_base_idx));

    assert_done_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(req_valid));

endmodule

bind lsu_top lsu_chk u_chk (.*);

// File: tb/lsu_top_tb_top.sv
`timescale 1ns/1ps
module lsu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [5:0]  req_op;
    logic [4:0]  req_a_idx, req_b_idx, req_c_idx;
    logic [31:0] req_a_val, req_b_val, req_c_val;
    logic [15:0] req_imm;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        done, misalign_err;
    logic        wb_ld_en, wb_base_en;
    logic [4:0]  wb_ld_idx, wb_base_idx;
    logic [31:0] wb_ld_data, wb_base_data;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [31:0] mem     [256];
    logic [31:0] ref_mem [256];
    logic [31:0] rf      [32];

    always #2.5 clk = ~clk;

    lsu_top dut_i (.*);

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] drv(input int i);
        return (i == 0) ? 32'hDEAD_BEEF : rf[i];
    endfunction

    task automatic do_op(input string tag, input logic [5:0] op,
                         input int a, input int b, input int c, input logic [15:0] imm);
        logic [31:0] va, vb, vc, sx, ea, nb, ld_val;
        bit ld, st, pop, psh, mis, go, e_ld, e_base;
        va = (a == 0) ? 32'h0 : rf[a];
        vb = (b == 0) ? 32'h0 : rf[b];
        vc = (c == 0) ? 32'h0 : rf[c];
        sx = {{16{imm[15]}}, imm};
        ld  = (op == 6'd32) || (op == 6'd33) || (op == 6'd34);
        st  = (op == 6'd36) || (op == 6'd37) || (op == 6'd38);
        pop = (op == 6'd34);
        psh = (op == 6'd38);
        nb  = vb + sx;
        case (op)
            6'd33, 6'd37: ea = vb + vc;
            6'd34:        ea = vb;
            default:      ea = vb + sx;
        endcase
        mis = (ld || st) && (ea[1:0] != 2'b00);
        go  = (ld || st) && !mis;

        req_valid = 1'b1; req_op = op;
        req_a_idx = 5'(a); req_b_idx = 5'(b); req_c_idx = 5'(c);
        req_a_val = drv(a); req_b_val = drv(b); req_c_val = drv(c);
        req_imm = imm;
        #1;
        chk(mem_req == go, tag, "mem_req", {31'b0, mem_req}, {31'b0, go});
        if (go) begin
            chk(mem_addr == ea, tag, "mem_addr", mem_addr, ea);
            chk(mem_we == st, tag, "mem_we", {31'b0, mem_we}, {31'b0, st});
            if (st) chk(mem_wdata == va, tag, "mem_wdata", mem_wdata, va);
        end
        ld_val = ref_mem[ea[9:2]];
        e_base = (pop || psh) && !mis && (b != 0);
        e_ld   = ld && !mis && (a != 0) && !(pop && a == b);
        if (st && !mis) ref_mem[ea[9:2]] = va;

        @(negedge clk);
        chk(done == (ld || st), tag, "done", {31'b0, done}, {31'b0, ld || st});
        chk(misalign_err == mis, tag, "misalign_err", {31'b0, misalign_err}, {31'b0, mis});
        chk(wb_ld_en == e_ld, tag, "wb_ld_en", {31'b0, wb_ld_en}, {31'b0, e_ld});
        if (e_ld) begin
            chk(wb_ld_idx == 5'(a), tag, "wb_ld_idx", {27'b0, wb_ld_idx}, a);
            chk(wb_ld_data == ld_val, tag, "wb_ld_data", wb_ld_data, ld_val);
        end
        chk(wb_base_en == e_base, tag, "wb_base_en", {31'b0, wb_base_en}, {31'b0, e_base});
        if (e_base) begin
            chk(wb_base_idx == 5'(b), tag, "wb_base_idx", {27'b0, wb_base_idx}, b);
            chk(wb_base_data == nb, tag, "wb_base_data", wb_base_data, nb);
        end
        if (e_ld)   rf[a] = ld_val;
        if (e_base) rf[b] = nb;
        req_valid = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 32'h1000_0000 + i * 32'h0001_0101;
            ref_mem[i] = mem[i];
        end
        for (int i = 0; i < 32; i++) rf[i] = 32'h0;
        rf[1] = 32'h100; rf[2] = 32'h10; rf[3] = 32'h203; rf[4] = 32'hFFFF_FFF8;
        rf[5] = 32'h1234_5678; rf[6] = 32'hA5A5_0001; rf[29] = 32'h300;
        mem_rdata = 32'h0;
        req_valid = 0; req_op = 0; req_imm = 0;
        req_a_idx = 0; req_b_idx = 0; req_c_idx = 0;
        req_a_val = 0; req_b_val = 0; req_c_val = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state, R9: nothing in flight
        chk(!done && !misalign_err, "R9", "reset done/err", {31'b0, done}, 32'h0);
        chk(!wb_ld_en && !wb_base_en, "R9", "reset writebacks", {31'b0, wb_ld_en}, 32'h0);
        chk(!mem_req, "R9", "reset mem_req", {31'b0, mem_req}, 32'h0);

        // R1 loads
        do_op("R1", 6'd32, 7, 1, 0, 16'h0008);
        do_op("R1", 6'd32, 8, 1, 0, 16'hFFFC);
        do_op("R1", 6'd33, 9, 1, 2, 16'h0000);
        // R2 stores, read back
        do_op("R2", 6'd36, 5, 1, 0, 16'h0020);
        do_op("R2", 6'd32, 10, 1, 0, 16'h0020);
        do_op("R2", 6'd37, 6, 1, 4, 16'h0000);
        do_op("R2", 6'd32, 17, 1, 0, 16'hFFF8);
        // R4 / R3 stack discipline
        do_op("R4", 6'd38, 5, 29, 0, 16'hFFFC);
        do_op("R4", 6'd38, 6, 29, 0, 16'hFFFC);
        do_op("R3", 6'd34, 11, 29, 0, 16'h0004);
        do_op("R3", 6'd34, 12, 29, 0, 16'h0004);
        // R5 pop into its own base
        rf[13] = 32'h40;
        do_op("R5", 6'd34, 13, 13, 0, 16'h0008);
        do_op("R5", 6'd32, 18, 13, 0, 16'h0000);
        // R6 register zero as operand
        do_op("R6", 6'd32, 14, 0, 0, 16'h0040);
        do_op("R6", 6'd36, 0, 1, 0, 16'h0030);
        do_op("R6", 6'd32, 19, 1, 0, 16'h0030);
        do_op("R6", 6'd33, 15, 1, 0, 16'h0000);
        // R7 writes to register zero dropped
        do_op("R7", 6'd32, 0, 1, 0, 16'h0004);
        do_op("R7", 6'd34, 0, 29, 0, 16'h0004);
        do_op("R7", 6'd38, 5, 0, 0, 16'h0050);
        do_op("R7", 6'd32, 20, 0, 0, 16'h0050);
        // R8 misaligned accesses
        do_op("R8", 6'd32, 16, 3, 0, 16'h0000);
        do_op("R8", 6'd36, 5, 1, 0, 16'h0002);
        do_op("R8", 6'd38, 6, 29, 0, 16'hFFFE);
        do_op("R8", 6'd34, 21, 29, 0, 16'h0004);
        do_op("R8", 6'd32, 22, 1, 0, 16'h0000);
        // R10 non-memory opcodes
        do_op("R10", 6'd0, 23, 1, 2, 16'h0000);
        do_op("R10", 6'd40, 24, 1, 0, 16'h0004);
        do_op("R10", 6'd35, 25, 1, 0, 16'h0004);
        do_op("R9", 6'd32, 26, 29, 0, 16'h0000);
        @(negedge clk);
        chk(!done, "R9", "idle after last op", {31'b0, done}, 32'h0);
        summary();
    end

endmodule